// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a small, fully associative translation cache. Each slot covers two adjacent virtual pages, an even page and an odd page, with one page table entry kept for each half. Each slot keeps its own page-size exponent, so different slots can map pages of different sizes. A slot also holds a page-pair tag made of virtual address bits 13 and up, an occupancy flag, an address-space identifier and a global flag. A lookup takes a virtual address and an address-space identifier. It returns the index of the slot that hit, the page table entry for the selected half and the page-size exponent. A separate permission checker uses those results.

Software-style maintenance uses four operations. An indexed read returns the whole contents of one slot. A fill writes a slot at an explicit index, or at a pseudo-random index drawn from a configurable window. Invalidation works in one of three ways: one slot by index, slots that match an address and identifier, or slots that match an address and are either global or carry that identifier. Every slot an invalidation removes produces one flush record. The record gives the base addresses of the even and odd pages, with an enable for each half, so that downstream translation caches can be flushed.

Top module: `pair_tlb`

## Requirements
- R1: After reset no slot is occupied, a lookup misses, `inv_busy` and `fl_valid` are 0, and an indexed read returns occupancy 0.
- R2: A fill writes the slot chosen on the clock edge where `wr_en` is sampled. The slot gets occupancy 1, the current `cur_asid`, and the supplied page-size exponent, tag, global flag and both page table entries, whatever the slot index. An indexed read returns these fields on the cycle after `rd_en`.
- R3: A lookup hits a slot only if all three conditions hold: the slot is occupied; (va >> (ps+1)) equals (tag >> (ps+1-13)), with ps ≥ 12; and either the slot's global flag is set or its identifier equals the lookup identifier. The result appears on the cycle after `lk_valid`, with `lk_rsp_valid` high.
- R4: On a hit, virtual address bit ps selects the half: 1 returns the odd page table entry and 0 returns the even one. The slot index and the page-size exponent are returned with it.
- R5: When several slots hit, the lowest index is reported.
- R6: A random fill (`wr_random`=1) writes a slot whose index lies in [`rand_lo`, `rand_hi`]. When the two bounds are equal, that index is used.
- R7: Invalidation mode 0 examines only slot `inv_idx`. `inv_busy` stays high for exactly 1 cycle. The slot's occupancy is cleared, and a flush record is produced if the slot was occupied.
- R8: Invalidation mode 1 examines all slots in ascending order, with `inv_busy` high for exactly ENTRIES cycles. It clears each occupied slot that is not global, whose page pair matches `inv_va` by the R3 comparison, and whose identifier equals `inv_asid`. A global slot is left in place.
- R9: Invalidation mode 2 scans like mode 1. It clears each occupied slot whose page pair matches and which is either global or carries `inv_asid`. Records come out in ascending slot order.
- R10: In a flush record, the even address is (tag << 13) with its low ps+1 bits cleared, sign-extended from the 48-bit virtual width to 64 bits. The odd address is the even address plus 2^ps. The even and odd enables equal bit 0 (the valid bit) of the even and odd page table entries, and `fl_ps` is the slot's exponent.
- R11: Unoccupied slots produce no flush record and no lookup hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 10 | Lookup address-space identifier |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of hitting slot |
| lk_pte | output | 64 | Selected page table entry |
| lk_ps | output | 6 | Page-size exponent of hitting slot |
| rd_en | input | 1 | Indexed read request |
| rd_idx | input | IDX_W | Slot to read |
| rd_rsp_valid | output | 1 | Read data valid |
| rd_exist | output | 1 | Slot occupancy |
| rd_glob | output | 1 | Slot global flag |
| rd_asid | output | 10 | Slot identifier |
| rd_ps | output | 6 | Slot page-size exponent |
| rd_vppn | output | 35 | Slot page-pair tag (VA bits 47:13) |
| rd_pte_even | output | 64 | Even page table entry |
| rd_pte_odd | output | 64 | Odd page table entry |
| wr_en | input | 1 | Fill request |
| wr_random | input | 1 | 1: pseudo-random index, 0: wr_idx |
| wr_idx | input | IDX_W | Explicit fill index |
| rand_lo | input | IDX_W | Random window low bound |
| rand_hi | input | IDX_W | Random window high bound |
| cur_asid | input | 10 | Identifier recorded on fill |
| wr_glob | input | 1 | Global flag to store |
| wr_ps | input | 6 | Page-size exponent to store |
| wr_vppn | input | 35 | Page-pair tag to store |
| wr_pte_even | input | 64 | Even page table entry to store |
| wr_pte_odd | input | 64 | Odd page table entry to store |
| inv_start | input | 1 | Start invalidation (ignored while busy) |
| inv_mode | input | 2 | 0 by index, 1 address+identifier, 2 address+identifier-or-global |
| inv_idx | input | IDX_W | Slot for mode 0 |
| inv_va | input | 48 | Address for modes 1 and 2 |
| inv_asid | input | 10 | Identifier for modes 1 and 2 |
| inv_busy | output | 1 | Invalidation scan in progress |
| fl_valid | output | 1 | Flush record valid |
| fl_even_en | output | 1 | Flush the even page |
| fl_odd_en | output | 1 | Flush the odd page |
| fl_even_addr | output | 64 | Even page base address |
| fl_odd_addr | output | 64 | Odd page base address |
| fl_ps | output | 6 | Page-size exponent of the flushed slot |

## Verification
Lookup and read results are registered, so each is due exactly one cycle after its request. A fill becomes visible to a lookup or read issued on the following cycle. The bench drives every request at a falling edge and samples at the next falling edge. The lookup driver pushes the expected result into a queue, and a monitor pops it at the falling edge where `lk_rsp_valid` shows. Invalidation records appear one per cycle while `inv_busy` is high, the last one in the cycle where busy drops. The bench therefore counts busy cycles (1 for mode 0, ENTRIES for modes 1 and 2) and lets the monitor match each `fl_valid` pulse against a queue of expected records in ascending slot order. After the scan it checks that no expected record is left over.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

    localparam int VA_W     = 48;
    localparam int ASID_W   = 10;
    localparam int PTE_W    = 64;
    localparam int PS_W     = 6;
    localparam int PAIR_LSB = 13;
    localparam int VPPN_W   = VA_W - PAIR_LSB;
    localparam int FL_W     = 64;
    localparam int PTE_V    = 0;

    typedef struct packed {
        logic              exist;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [PS_W-1:0]   ps;
        logic [VPPN_W-1:0] vppn;
        logic [PTE_W-1:0]  pte_even;
        logic [PTE_W-1:0]  pte_odd;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        INV_BY_INDEX     = 2'd0,
        INV_BY_ASID      = 2'd1,
        INV_BY_ASID_OR_G = 2'd2,
        INV_NONE         = 2'd3
    } inv_mode_e;

    // Page-pair comparison: both sides aligned to a 2^(ps+1) pair.
    function automatic logic pair_eq(input logic [VPPN_W-1:0] vppn,
                                     input logic [PS_W-1:0]   ps,
                                     input logic [VA_W-1:0]   va);
        logic [VA_W-1:0] va_sh;
        logic [VA_W-1:0] tag_sh;
        va_sh  = va >> (int'(ps) + 1);
        tag_sh = VA_W'(vppn) >> (int'(ps) + 1 - PAIR_LSB);
        return va_sh == tag_sh;
    endfunction

    // Even-page base of a pair, sign-extended to the flush width.
    function automatic logic [FL_W-1:0] pair_base(input logic [VPPN_W-1:0] vppn,
                                                  input logic [PS_W-1:0]   ps);
        logic [VA_W-1:0] b;
        b = {vppn, {PAIR_LSB{1'b0}}};
        b = b & ~((VA_W'(1) << (int'(ps) + 1)) - VA_W'(1));
        return {{(FL_W-VA_W){b[VA_W-1]}}, b};
    endfunction

endpackage

// File: rtl/pair_tlb_lfsr.sv
module pair_tlb_lfsr
    #(parameter int IDX_W = 3)
    (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lo,
    input  logic [IDX_W-1:0] hi,
    output logic [IDX_W-1:0] idx
    );

    localparam int LFSR_W = 16;

    logic [LFSR_W-1:0] lfsr;
    logic [IDX_W:0]    span;
    logic [LFSR_W-1:0] off;

    always_ff @(posedge clk) begin
        if (rst)
            lfsr <= 16'hACE1;
        else
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    always_comb begin
        span = (hi >= lo) ? ({1'b0, hi} - {1'b0, lo} + 1'b1) : (IDX_W+1)'(1);
        off  = lfsr % LFSR_W'(span);
        idx  = lo + IDX_W'(off);
    end

    a_r6_random_in_range: assert property (@(posedge clk) disable iff (rst)
        (hi >= lo) |-> (idx >= lo && idx <= hi));

endmodule

// File: rtl/pair_tlb_lookup.sv
module pair_tlb_lookup
    import pair_tlb_pkg::*;
    #(parameter int N = 8,
      localparam int IDX_W = $clog2(N))
    (
    input  tlb_ent_t [N-1:0]   ents,
    input  logic [VA_W-1:0]    va,
    input  logic [ASID_W-1:0]  asid,
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic [PTE_W-1:0]   pte,
    output logic [PS_W-1:0]    ps
    );

    logic [N-1:0] hv;
    tlb_ent_t     sel;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hv[g] = ents[g].exist
                     && pair_eq(ents[g].vppn, ents[g].ps, va)
                     && (ents[g].glob || ents[g].asid == asid);
    end

    // Lowest index wins: scan downward so the last assignment is the lowest.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
        sel = ents[idx];
        pte = va[sel.ps] ? sel.pte_odd : sel.pte_even;
        ps  = sel.ps;
    end

endmodule

// File: rtl/pair_tlb_scan.sv
module pair_tlb_scan
    import pair_tlb_pkg::*;
    #(parameter int N = 8,
      localparam int IDX_W = $clog2(N))
    (
    input  logic               clk,
    input  logic               rst,
    input  tlb_ent_t [N-1:0]   ents,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic [IDX_W-1:0]   idx_in,
    input  logic [VA_W-1:0]    va,
    input  logic [ASID_W-1:0]  asid,
    output logic               busy,
    output logic               clr_en,
    output logic [IDX_W-1:0]   clr_idx,
    output logic               fl_valid,
    output logic               fl_even_en,
    output logic               fl_odd_en,
    output logic [FL_W-1:0]    fl_even_addr,
    output logic [FL_W-1:0]    fl_odd_addr,
    output logic [PS_W-1:0]    fl_ps
    );

    inv_mode_e         mode_q;
    logic [VA_W-1:0]   va_q;
    logic [ASID_W-1:0] asid_q;
    logic [IDX_W-1:0]  cur;
    logic [IDX_W-1:0]  last;
    tlb_ent_t          e;
    logic              match;
    logic              hit_cur;
    logic [FL_W-1:0]   base;

    always_comb begin
        e     = ents[cur];
        match = pair_eq(e.vppn, e.ps, va_q);
        case (mode_q)
            INV_BY_INDEX:     hit_cur = e.exist;
            INV_BY_ASID:      hit_cur = e.exist && match && !e.glob && e.asid == asid_q;
            INV_BY_ASID_OR_G: hit_cur = e.exist && match && (e.glob || e.asid == asid_q);
            default:          hit_cur = 1'b0;
        endcase
        base = pair_base(e.vppn, e.ps);
    end

    assign clr_en  = busy && hit_cur;
    assign clr_idx = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy         <= 1'b0;
            mode_q       <= INV_NONE;
            va_q         <= '0;
            asid_q       <= '0;
            cur          <= '0;
            last         <= '0;
            fl_valid     <= 1'b0;
            fl_even_en   <= 1'b0;
            fl_odd_en    <= 1'b0;
            fl_even_addr <= '0;
            fl_odd_addr  <= '0;
            fl_ps        <= '0;
        end else begin
            fl_valid <= 1'b0;
            if (!busy && start) begin
                busy   <= 1'b1;
                mode_q <= inv_mode_e'(mode);
                va_q   <= va;
                asid_q <= asid;
                cur    <= (mode == INV_BY_INDEX) ? idx_in : '0;
                last   <= (mode == INV_BY_INDEX) ? idx_in : IDX_W'(N - 1);
            end else if (busy) begin
                fl_valid     <= hit_cur;
                fl_even_en   <= e.pte_even[PTE_V];
                fl_odd_en    <= e.pte_odd[PTE_V];
                fl_even_addr <= base;
                fl_odd_addr  <= base + (FL_W'(1) << e.ps);
                fl_ps        <= e.ps;
                if (cur == last) busy <= 1'b0;
                else             cur  <= cur + 1'b1;
            end
        end
    end

    logic [IDX_W+1:0] bcnt;
    always_ff @(posedge clk) begin
        if (rst)       bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    a_r8_scan_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(bcnt) < N));

    a_r7_record_needs_scan: assert property (@(posedge clk) disable iff (rst)
        fl_valid |-> $past(busy));

    a_r10_base_aligned: assert property (@(posedge clk) disable iff (rst)
        fl_valid |-> ((fl_even_addr[VA_W-1:0]
                      & ((VA_W'(1) << (int'(fl_ps) + 1)) - VA_W'(1))) == '0));

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
    import pair_tlb_pkg::*;
    #(parameter int N = 8,
      localparam int IDX_W = $clog2(N))
    (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_va,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_rsp_valid,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [PTE_W-1:0]   lk_pte,
    output logic [PS_W-1:0]    lk_ps,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_rsp_valid,
    output logic               rd_exist,
    output logic               rd_glob,
    output logic [ASID_W-1:0]  rd_asid,
    output logic [PS_W-1:0]    rd_ps,
    output logic [VPPN_W-1:0]  rd_vppn,
    output logic [PTE_W-1:0]   rd_pte_even,
    output logic [PTE_W-1:0]   rd_pte_odd,
    input  logic               wr_en,
    input  logic               wr_random,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [IDX_W-1:0]   rand_lo,
    input  logic [IDX_W-1:0]   rand_hi,
    input  logic [ASID_W-1:0]  cur_asid,
    input  logic               wr_glob,
    input  logic [PS_W-1:0]    wr_ps,
    input  logic [VPPN_W-1:0]  wr_vppn,
    input  logic [PTE_W-1:0]   wr_pte_even,
    input  logic [PTE_W-1:0]   wr_pte_odd,
    input  logic               inv_start,
    input  logic [1:0]         inv_mode,
    input  logic [IDX_W-1:0]   inv_idx,
    input  logic [VA_W-1:0]    inv_va,
    input  logic [ASID_W-1:0]  inv_asid,
    output logic               inv_busy,
    output logic               fl_valid,
    output logic               fl_even_en,
    output logic               fl_odd_en,
    output logic [FL_W-1:0]    fl_even_addr,
    output logic [FL_W-1:0]    fl_odd_addr,
    output logic [PS_W-1:0]    fl_ps
    );

    tlb_ent_t [N-1:0]  ents;
    tlb_ent_t          new_ent;
    tlb_ent_t          rd_q;
    logic [IDX_W-1:0]  rnd_idx;
    logic [IDX_W-1:0]  fill_idx;
    logic              clr_en;
    logic [IDX_W-1:0]  clr_idx;
    logic              lk_hit_c;
    logic [IDX_W-1:0]  lk_idx_c;
    logic [PTE_W-1:0]  lk_pte_c;
    logic [PS_W-1:0]   lk_ps_c;

    pair_tlb_lfsr #(.IDX_W(IDX_W)) u_lfsr (
        .clk (clk), .rst (rst), .lo (rand_lo), .hi (rand_hi), .idx (rnd_idx)
    );

    pair_tlb_lookup #(.N(N)) u_lookup (
        .ents (ents), .va (lk_va), .asid (lk_asid),
        .hit (lk_hit_c), .idx (lk_idx_c), .pte (lk_pte_c), .ps (lk_ps_c)
    );

    pair_tlb_scan #(.N(N)) u_scan (
        .clk (clk), .rst (rst), .ents (ents),
        .start (inv_start), .mode (inv_mode), .idx_in (inv_idx),
        .va (inv_va), .asid (inv_asid),
        .busy (inv_busy), .clr_en (clr_en), .clr_idx (clr_idx),
        .fl_valid (fl_valid), .fl_even_en (fl_even_en), .fl_odd_en (fl_odd_en),
        .fl_even_addr (fl_even_addr), .fl_odd_addr (fl_odd_addr), .fl_ps (fl_ps)
    );

    assign fill_idx = wr_random ? rnd_idx : wr_idx;

    always_comb begin
        new_ent.exist    = 1'b1;
        new_ent.glob     = wr_glob;
        new_ent.asid     = cur_asid;
        new_ent.ps       = wr_ps;
        new_ent.vppn     = wr_vppn;
        new_ent.pte_even = wr_pte_even;
        new_ent.pte_odd  = wr_pte_odd;
    end

    // A fill on the same edge as a scan clear of that slot wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
        end else begin
            if (clr_en) ents[clr_idx].exist <= 1'b0;
            if (wr_en)  ents[fill_idx]      <= new_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_rsp_valid <= 1'b0;
            lk_hit       <= 1'b0;
            lk_idx       <= '0;
            lk_pte       <= '0;
            lk_ps        <= '0;
            rd_rsp_valid <= 1'b0;
            rd_q         <= '0;
        end else begin
            lk_rsp_valid <= lk_valid;
            lk_hit       <= lk_valid && lk_hit_c;
            lk_idx       <= lk_idx_c;
            lk_pte       <= lk_pte_c;
            lk_ps        <= lk_ps_c;
            rd_rsp_valid <= rd_en;
            if (rd_en) rd_q <= ents[rd_idx];
        end
    end

    assign rd_exist    = rd_q.exist;
    assign rd_glob     = rd_q.glob;
    assign rd_asid     = rd_q.asid;
    assign rd_ps       = rd_q.ps;
    assign rd_vppn     = rd_q.vppn;
    assign rd_pte_even = rd_q.pte_even;
    assign rd_pte_odd  = rd_q.pte_odd;

    a_r2_fill_sets_exist: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ents[$past(fill_idx)].exist);

    a_r3_hit_slot_valid: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hit_c) |-> (ents[lk_idx_c].exist
            && (ents[lk_idx_c].glob || ents[lk_idx_c].asid == lk_asid)));

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!inv_busy && !fl_valid && !lk_rsp_valid));

endmodule

// File: tb/pair_tlb_bench.sv
module pair_tlb_bench;
    import pair_tlb_pkg::*;

    localparam int N     = 8;
    localparam int IDX_W = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic               lk_valid = 0;
    logic [VA_W-1:0]    lk_va = '0;
    logic [ASID_W-1:0]  lk_asid = '0;
    logic               lk_rsp_valid, lk_hit;
    logic [IDX_W-1:0]   lk_idx;
    logic [PTE_W-1:0]   lk_pte;
    logic [PS_W-1:0]    lk_ps;
    logic               rd_en = 0;
    logic [IDX_W-1:0]   rd_idx = '0;
    logic               rd_rsp_valid, rd_exist, rd_glob;
    logic [ASID_W-1:0]  rd_asid;
    logic [PS_W-1:0]    rd_ps;
    logic [VPPN_W-1:0]  rd_vppn;
    logic [PTE_W-1:0]   rd_pte_even, rd_pte_odd;
    logic               wr_en = 0, wr_random = 0, wr_glob = 0;
    logic [IDX_W-1:0]   wr_idx = '0, rand_lo = '0, rand_hi = '0;
    logic [ASID_W-1:0]  cur_asid = '0;
    logic [PS_W-1:0]    wr_ps = '0;
    logic [VPPN_W-1:0]  wr_vppn = '0;
    logic [PTE_W-1:0]   wr_pte_even = '0, wr_pte_odd = '0;
    logic               inv_start = 0;
    logic [1:0]         inv_mode = '0;
    logic [IDX_W-1:0]   inv_idx = '0;
    logic [VA_W-1:0]    inv_va = '0;
    logic [ASID_W-1:0]  inv_asid = '0;
    logic               inv_busy, fl_valid, fl_even_en, fl_odd_en;
    logic [FL_W-1:0]    fl_even_addr, fl_odd_addr;
    logic [PS_W-1:0]    fl_ps;

    pair_tlb #(.N(N)) u_pair_tlb (.*);

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        string          tag;
        logic           hit;
        int             lo;
        int             hi;
        logic [63:0]    pte;
        int             ps;
    } lk_exp_t;

    typedef struct {
        string          tag;
        logic           even_en;
        logic           odd_en;
        logic [63:0]    even_addr;
        logic [63:0]    odd_addr;
        int             ps;
    } fl_exp_t;

    lk_exp_t lk_q[$];
    fl_exp_t fl_q[$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected pair base from R10, written independently of the design.
    function automatic logic [63:0] exp_base(input logic [VA_W-1:0] va, input int ps);
        logic [VA_W-1:0] b;
        b = (va >> 13) << 13;
        b = (b >> (ps + 1)) << (ps + 1);
        return {{16{b[47]}}, b};
    endfunction

    // Monitor: pops the scoreboards at the falling edge where results show.
    always @(negedge clk) begin
        if (!rst) begin
            if (lk_rsp_valid) begin
                if (lk_q.size() == 0) chk("R3 unexpected lookup response", 1, 0);
                else begin
                    lk_exp_t e;
                    e = lk_q.pop_front();
                    chk({e.tag, " hit"}, lk_hit, e.hit);
                    if (e.hit && lk_hit) begin
                        chk({e.tag, " index in range"},
                            (int'(lk_idx) >= e.lo && int'(lk_idx) <= e.hi), 1);
                        chk({e.tag, " pte"}, lk_pte, e.pte);
                        chk({e.tag, " ps"}, lk_ps, e.ps);
                    end
                end
            end
            if (fl_valid) begin
                if (fl_q.size() == 0) chk("R11 unexpected flush record", 1, 0);
                else begin
                    fl_exp_t f;
                    f = fl_q.pop_front();
                    chk({f.tag, " even addr"}, fl_even_addr, f.even_addr);
                    chk({f.tag, " odd addr"}, fl_odd_addr, f.odd_addr);
                    chk({f.tag, " even en"}, fl_even_en, f.even_en);
                    chk({f.tag, " odd en"}, fl_odd_en, f.odd_en);
                    chk({f.tag, " ps"}, fl_ps, f.ps);
                end
            end
        end
    end

    task automatic do_fill(input logic rnd, input int idx, input logic [VA_W-1:0] va,
                           input int ps, input logic g, input int asid,
                           input logic [63:0] pe, input logic [63:0] po);
        @(negedge clk);
        wr_en = 1; wr_random = rnd; wr_idx = IDX_W'(idx);
        wr_vppn = va[VA_W-1:13]; wr_ps = PS_W'(ps); wr_glob = g;
        cur_asid = ASID_W'(asid); wr_pte_even = pe; wr_pte_odd = po;
        @(negedge clk);
        wr_en = 0; wr_random = 0;
    endtask

    task automatic do_lookup(input string tag, input logic [VA_W-1:0] va, input int asid,
                             input logic hit, input int lo, input int hi,
                             input logic [63:0] pte, input int ps);
        lk_exp_t e;
        e.tag = tag; e.hit = hit; e.lo = lo; e.hi = hi; e.pte = pte; e.ps = ps;
        @(negedge clk);
        lk_q.push_back(e);
        lk_valid = 1; lk_va = va; lk_asid = ASID_W'(asid);
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic expect_flush(input string tag, input logic [VA_W-1:0] va, input int ps,
                                input logic ee, input logic oe);
        fl_exp_t f;
        f.tag = tag; f.even_en = ee; f.odd_en = oe; f.ps = ps;
        f.even_addr = exp_base(va, ps);
        f.odd_addr  = f.even_addr + (64'd1 << ps);
        fl_q.push_back(f);
    endtask

    task automatic do_inv(input string tag, input int mode, input int idx,
                          input logic [VA_W-1:0] va, input int asid, input int exp_cycles);
        int cnt;
        @(negedge clk);
        inv_start = 1; inv_mode = 2'(mode); inv_idx = IDX_W'(idx);
        inv_va = va; inv_asid = ASID_W'(asid);
        @(negedge clk);
        inv_start = 0;
        cnt = 0;
        while (inv_busy) begin
            cnt++;
            @(negedge clk);
        end
        @(negedge clk);
        chk({tag, " busy cycles"}, cnt, exp_cycles);
        chk({tag, " all records seen"}, fl_q.size(), 0);
        fl_q.delete();
    endtask

    localparam logic [VA_W-1:0] VA_A  = 48'h0000_1234_4000;
    localparam logic [VA_W-1:0] VA_B2 = 48'h0000_4070_1000;
    localparam logic [VA_W-1:0] VA_BE = 48'h0000_4040_1234;
    localparam logic [VA_W-1:0] VA_E  = 48'h8000_0000_2000;
    localparam logic [VA_W-1:0] VA_F  = 48'h0000_0ABC_0000;
    localparam logic [VA_W-1:0] VA_C  = 48'h0000_0777_0000;
    localparam logic [VA_W-1:0] VA_D  = 48'h0000_0555_0000;

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy after reset", inv_busy, 0);
        chk("R1 flush after reset", fl_valid, 0);
        chk("R1 lookup rsp after reset", lk_rsp_valid, 0);
        @(negedge clk); rd_en = 1; rd_idx = 3;
        @(negedge clk); rd_en = 0;
        chk("R1 read valid", rd_rsp_valid, 1);
        chk("R1 slot unoccupied", rd_exist, 0);
        do_lookup("R1 lookup miss", VA_A, 5, 0, 0, 0, 0, 0);

        // R2 fill and read back
        do_fill(0, 2, VA_A, 12, 0, 5, 64'h0000_0000_0AAA_0001, 64'h0000_0000_0AAB_0001);
        do_fill(0, 7, VA_B2, 21, 1, 9, 64'h0000_0000_0BB0_0000, 64'h0000_0000_0BB1_0001);
        @(negedge clk); rd_en = 1; rd_idx = 2;
        @(negedge clk); rd_en = 0;
        chk("R2 read exist", rd_exist, 1);
        chk("R2 read asid", rd_asid, 5);
        chk("R2 read ps", rd_ps, 12);
        chk("R2 read vppn", rd_vppn, VA_A[47:13]);
        chk("R2 read glob", rd_glob, 0);
        chk("R2 read pte even", rd_pte_even, 64'h0000_0000_0AAA_0001);
        chk("R2 read pte odd", rd_pte_odd, 64'h0000_0000_0AAB_0001);
        @(negedge clk); rd_en = 1; rd_idx = 7;
        @(negedge clk); rd_en = 0;
        chk("R2 read ps at slot 7", rd_ps, 21);
        chk("R2 read glob at slot 7", rd_glob, 1);

        // R3 / R4 lookups
        do_lookup("R4 even half", VA_A, 5, 1, 2, 2, 64'h0000_0000_0AAA_0001, 12);
        do_lookup("R4 odd half", VA_A + 48'h1000, 5, 1, 2, 2, 64'h0000_0000_0AAB_0001, 12);
        do_lookup("R3 asid mismatch", VA_A, 6, 0, 0, 0, 0, 0);
        do_lookup("R3 other pair", VA_A + 48'h2000, 5, 0, 0, 0, 0, 0);
        do_lookup("R3 global odd large page", VA_B2, 3, 1, 7, 7, 64'h0000_0000_0BB1_0001, 21);
        do_lookup("R4 global even large page", VA_BE, 3, 1, 7, 7, 64'h0000_0000_0BB0_0000, 21);

        // R5 multiple hits
        do_fill(0, 5, VA_F, 12, 0, 7, 64'h0000_0000_0F50_0000, 64'h0000_0000_0F51_0001);
        do_fill(0, 1, VA_F, 12, 0, 7, 64'h0000_0000_0F10_0001, 64'h0000_0000_0F11_0000);
        do_lookup("R5 lowest index", VA_F, 7, 1, 1, 1, 64'h0000_0000_0F10_0001, 12);

        // R11 / R7 index invalidate of an empty slot
        do_inv("R11 empty slot by index", 0, 3, '0, 0, 1);

        // R8 address + identifier
        expect_flush("R8 R10 flush slot 2", VA_A, 12, 1, 1);
        do_inv("R8 by asid", 1, 0, VA_A, 5, N);
        do_lookup("R8 cleared slot misses", VA_A, 5, 0, 0, 0, 0, 0);
        do_inv("R8 global kept", 1, 0, VA_B2, 9, N);
        do_lookup("R8 global still hits", VA_B2, 3, 1, 7, 7, 64'h0000_0000_0BB1_0001, 21);

        // R9 address + identifier or global
        expect_flush("R9 R10 flush global", VA_B2, 21, 0, 1);
        do_inv("R9 global cleared", 2, 0, VA_B2, 3, N);
        do_lookup("R9 global now misses", VA_B2, 3, 0, 0, 0, 0, 0);
        expect_flush("R9 order slot 1", VA_F, 12, 1, 0);
        expect_flush("R9 order slot 5", VA_F, 12, 0, 1);
        do_inv("R9 two slots", 2, 0, VA_F, 7, N);

        // R7 / R10 sign extension via index invalidate
        do_fill(0, 0, VA_E, 12, 0, 1, 64'h0000_0000_0EE0_0001, 64'h0000_0000_0EE1_0001);
        do_lookup("R3 upper-half address hit", VA_E, 1, 1, 0, 0, 64'h0000_0000_0EE0_0001, 12);
        chk("R10 sign-extended base", exp_base(VA_E, 12), 64'hFFFF_8000_0000_2000);
        expect_flush("R7 R10 index flush", VA_E, 12, 1, 1);
        do_inv("R7 by index", 0, 0, '0, 0, 1);
        do_lookup("R7 cleared by index", VA_E, 1, 0, 0, 0, 0, 0);

        // R6 random fill
        @(negedge clk); rand_lo = 4; rand_hi = 4;
        do_fill(1, 0, VA_C, 12, 0, 2, 64'h0000_0000_0CC0_0001, 64'h0000_0000_0CC1_0001);
        do_lookup("R6 equal bounds", VA_C, 2, 1, 4, 4, 64'h0000_0000_0CC0_0001, 12);
        @(negedge clk); rand_lo = 3; rand_hi = 6;
        do_fill(1, 0, VA_D, 12, 0, 2, 64'h0000_0000_0DD0_0001, 64'h0000_0000_0DD1_0001);
        do_lookup("R6 window", VA_D, 2, 1, 3, 6, 64'h0000_0000_0DD0_0001, 12);

        repeat (3) @(negedge clk);
        chk("R3 all lookups answered", lk_q.size(), 0);
        finish_run();
    end

endmodule